// File: doc/BRIEF.md
# Single-Shot Pulse Timer

This timer channel emits exactly one output pulse for each start event. A run bit does two jobs: it is the start request and it is the pulse level. Software sets it through a small register port. A rising edge on an external trigger pin can set it as well. While the bit is high, an up-counter advances once per clock-enable tick. When the count reaches the compare-A value, the run bit clears on its own, the pulse ends, and a sticky interrupt flag is raised. The compare-A value therefore sets the pulse width in ticks.

Pulse behaviour applies only when two control fields hold the single-shot codes. Outside that combination the output stays low, the trigger pin is ignored, and compare matches neither stop the counter nor raise the interrupt. The counter returns to zero only at the moment the run bit rises. When a pulse ends, the counter keeps its last value, and software can read it back.

The register port is a plain single-cycle write strobe with an address. Read data is combinational from the address. There is no streaming data path, so no valid/ready handshake applies.

Top module: `spt_timer`

## Requirements
- R1: After reset, `pulse_o` and `irq_o` are 0, and the control word (address 0) and the count (address 3) both read 0.
- R2: Single-shot operation requires the mode field (control bits 2:1) to equal 2'b10 and the output field (bits 4:3) to equal 2'b11. With any other codes, `pulse_o` stays 0 and a trigger pin edge does not set the run bit (bit 0).
- R3: If the run bit is 0, writing the control word with bit 0 = 1 sets it. `pulse_o` is high from the next cycle, and the count reads 0 in that cycle.
- R4: A rising edge on `trig_i` sets the run bit on the third clock edge after the pin rises (two synchronizer stages plus an edge stage). An edge that arrives while the run bit is already 1 has no effect.
- R5: With a tick in every cycle, the pulse lasts exactly N cycles for a compare-A value N (address 1). The run bit then clears on its own, and the count holds N.
- R6: A compare-A match sets the interrupt flag (control bit 7, `irq_o`). The flag stays set until the control word is written with bit 7 = 1. If a match and a clear happen in the same cycle, the flag ends up set.
- R7: Writing the control word with bit 0 = 0 ends the pulse on that edge. The count keeps the value reached, including the tick of that edge.
- R8: The count does not change while the run bit stays 0. It is zeroed only when the run bit rises.
- R9: The period register (address 2) and the counter-clear bit (control bit 5) do not change the pulse width.
- R10: A compare-A value of 0 gives a pulse of 2^10 = 1024 ticks, after which the count wraps to 0.
- R11: A software clear and a compare-A match in the same cycle leave the run bit 0 and the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter clock enable |
| trig_i | input | 1 | Asynchronous external start pin |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 compare-A, 2 period, 3 count |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` |
| pulse_o | output | 1 | Single-shot pulse output |
| irq_o | output | 1 | Sticky compare-A interrupt flag |

## Verification
A stuck or mis-set run bit shows at once on `pulse_o`, because the output is the run bit gated by the mode decode. A scoreboard measures every pulse width in cycles and compares it against the compare-A value queued by the driver, so an off-by-one in the counter or the compare shows up as soon as that pulse falls. Counter state that should persist after a stop is read back through the count register a few cycles later. A lost trigger or a spurious retrigger shows as a missing or extra pulse within three cycles of the pin edge.

// File: rtl/spt_pkg.sv
`timescale 1ns/1ps
package spt_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CMPA = 2'd1,
    ADDR_PER  = 2'd2,
    ADDR_CNT  = 2'd3
  } spt_addr_e;

  // control word bit layout
  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned MODE_LSB = 1;
  localparam int unsigned OC_LSB   = 3;
  localparam int unsigned CCLR_BIT = 5;
  localparam int unsigned IRQ_BIT  = 7;

  localparam logic [1:0] MODE_SINGLE = 2'b10;
  localparam logic [1:0] OC_SINGLE   = 2'b11;
endpackage

// File: rtl/spt_sync_edge.sv
`timescale 1ns/1ps
// Multi-stage synchronizer followed by a rising-edge detector.
module spt_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/spt_counter.sv
`timescale 1ns/1ps
// Up-counter with compare against either the full count or its upper bits.
module spt_counter #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned CMPA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              start_i,
  input  logic [CMPA_W-1:0] cmpa_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              match_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             hit;

  assign cnt_nx = cnt_q + 1'b1;

  generate
    if (CMPA_W == CNT_W) begin : g_full
      assign hit = (cnt_nx == cmpa_i);
    end else begin : g_upper
      localparam int unsigned LOW_W = CNT_W - CMPA_W;
      assign hit = (cnt_nx[CNT_W-1:LOW_W] == cmpa_i) && (cnt_nx[LOW_W-1:0] == '0);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= cnt_nx;
  end

  assign match_o = run_i & tick_i & hit;
  assign count_o = cnt_q;
endmodule

// File: rtl/spt_ctrl.sv
`timescale 1ns/1ps
// Run bit (pulse state) and sticky interrupt flag.
module spt_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sp_mode_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  input  logic trig_rise_i,
  input  logic match_i,
  input  logic irq_clr_i,
  output logic run_o,
  output logic start_o,
  output logic irq_o
);
  logic run_q, run_d, irq_q, match_eff;

  assign match_eff = match_i & sp_mode_i;

  always_comb begin
    run_d = run_q;
    if (run_q) begin
      if (match_eff || sw_clr_i) run_d = 1'b0;
    end else if (sw_set_i || (trig_rise_i && sp_mode_i)) begin
      run_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      run_q <= run_d;
      if (match_eff)      irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign start_o = run_d & ~run_q;
  assign run_o   = run_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/spt_regs.sv
`timescale 1ns/1ps
// Register port: configuration storage, write decode and read mux.
module spt_regs
  import spt_pkg::*;
#(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned CMPA_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              run_i,
  input  logic              irq_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sp_mode_o,
  output logic              sw_set_o,
  output logic              sw_clr_o,
  output logic              irq_clr_o,
  output logic [CMPA_W-1:0] cmpa_o
);
  logic [1:0]        mode_q, oc_q;
  logic              cclr_q;
  logic [CMPA_W-1:0] cmpa_q;
  logic [DATA_W-1:0] per_q;
  logic              wr_ctrl, wr_cmpa, wr_per;

  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign wr_cmpa = we_i && (addr_i == ADDR_CMPA);
  assign wr_per  = we_i && (addr_i == ADDR_PER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      oc_q   <= '0;
      cclr_q <= 1'b0;
      cmpa_q <= '0;
      per_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        mode_q <= wdata_i[MODE_LSB +: 2];
        oc_q   <= wdata_i[OC_LSB +: 2];
        cclr_q <= wdata_i[CCLR_BIT];
      end
      if (wr_cmpa) cmpa_q <= wdata_i[CMPA_W-1:0];
      if (wr_per)  per_q  <= wdata_i;
    end
  end

  assign sw_set_o  = wr_ctrl &  wdata_i[RUN_BIT];
  assign sw_clr_o  = wr_ctrl & ~wdata_i[RUN_BIT];
  assign irq_clr_o = wr_ctrl &  wdata_i[IRQ_BIT];
  assign sp_mode_o = (mode_q == MODE_SINGLE) && (oc_q == OC_SINGLE);
  assign cmpa_o    = cmpa_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[RUN_BIT]       = run_i;
        rdata_o[MODE_LSB +: 2] = mode_q;
        rdata_o[OC_LSB +: 2]   = oc_q;
        rdata_o[CCLR_BIT]      = cclr_q;
        rdata_o[IRQ_BIT]       = irq_i;
      end
      ADDR_CMPA: rdata_o[CMPA_W-1:0] = cmpa_q;
      ADDR_PER:  rdata_o = per_q;
      default:   rdata_o[CNT_W-1:0] = count_i;
    endcase
  end
endmodule

// File: rtl/spt_timer.sv
`timescale 1ns/1ps
// Single-shot pulse timer channel, top level.
module spt_timer
  import spt_pkg::*;
#(
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned CMPA_W      = 10,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              trig_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              pulse_o,
  output logic              irq_o
);
  logic              run_w, start_w, match_w, trig_rise_w;
  logic              sp_mode_w, sw_set_w, sw_clr_w, irq_clr_w, irq_w;
  logic [CNT_W-1:0]  count_w;
  logic [CMPA_W-1:0] cmpa_w;

  spt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (trig_i),
    .rise_o  (trig_rise_w)
  );

  spt_regs #(.CNT_W(CNT_W), .CMPA_W(CMPA_W), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .run_i     (run_w),
    .irq_i     (irq_w),
    .count_i   (count_w),
    .rdata_o   (reg_rdata_o),
    .sp_mode_o (sp_mode_w),
    .sw_set_o  (sw_set_w),
    .sw_clr_o  (sw_clr_w),
    .irq_clr_o (irq_clr_w),
    .cmpa_o    (cmpa_w)
  );

  spt_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sp_mode_i   (sp_mode_w),
    .sw_set_i    (sw_set_w),
    .sw_clr_i    (sw_clr_w),
    .trig_rise_i (trig_rise_w),
    .match_i     (match_w),
    .irq_clr_i   (irq_clr_w),
    .run_o       (run_w),
    .start_o     (start_w),
    .irq_o       (irq_w)
  );

  spt_counter #(.CNT_W(CNT_W), .CMPA_W(CMPA_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .run_i   (run_w),
    .start_i (start_w),
    .cmpa_i  (cmpa_w),
    .count_o (count_w),
    .match_o (match_w)
  );

  assign pulse_o = run_w & sp_mode_w;
  assign irq_o   = irq_w;
endmodule

// File: rtl/spt_sva.sv
`timescale 1ns/1ps
module spt_sva #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             run_i,
  input logic             match_i,
  input logic             sp_mode_i,
  input logic             irq_clr_i,
  input logic [CNT_W-1:0] count_i,
  input logic             pulse_i,
  input logic             irq_i
);
  // R2
  p_pulse_needs_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |-> sp_mode_i);

  // R3
  p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i) |=> (count_i == $past(count_i) + 1'b1));

  // R5
  p_match_ends_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && sp_mode_i) |=> !run_i);

  // R6
  p_match_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && sp_mode_i) |=> irq_i);

  // R6
  p_irq_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !irq_clr_i) |=> irq_i);

  // R8
  p_start_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (count_i == '0));

  // R8
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && $past(!run_i)) |-> $stable(count_i));
endmodule

bind spt_timer spt_sva #(.CNT_W(CNT_W)) i_spt_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .run_i     (run_w),
  .match_i   (match_w),
  .sp_mode_i (sp_mode_w),
  .irq_clr_i (irq_clr_w),
  .count_i   (count_w),
  .pulse_i   (pulse_o),
  .irq_i     (irq_o)
);

// File: tb/test_spt_timer.sv
`timescale 1ns/1ps
module test_spt_timer;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b1;
  logic              trig = 1'b0;
  logic              we = 1'b0;
  logic [1:0]        addr = 2'd0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              pulse, irq;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  int hi_len = 0;
  bit done = 1'b0;

  // 100 MHz
  always #5 clk = ~clk;

  spt_timer i_spt_timer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .trig_i      (trig),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .pulse_o     (pulse),
    .irq_o       (irq)
  );

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ctrl(int run, int mode, int oc, int cclr, int iclr);
    return run | (mode << 1) | (oc << 3) | (cclr << 5) | (iclr << 7);
  endfunction

  task automatic wr(logic [1:0] a, int d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d[DATA_W-1:0];
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int d);
    addr = a;
    #1;
    d = int'(rdata);
  endtask

  task automatic wait_fall();
    @(negedge clk);
    while (pulse) @(negedge clk);
  endtask

  // Monitor: measure each pulse and compare against the scoreboard queue (R5)
  always @(negedge clk) begin
    int e;
    if (rst_n) begin
      if (pulse) hi_len++;
      else if (hi_len > 0) begin
        if (exp_q.size() == 0) check("R5 unexpected pulse width", hi_len, 0);
        else begin
          e = exp_q.pop_front();
          check("R5 pulse width", hi_len, e);
        end
        hi_len = 0;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pulse", int'(pulse), 0);
    check("R1 irq", int'(irq), 0);
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd3, v); check("R1 count", v, 0);

    // R3 / R5 software start, width 5
    wr(2'd1, 5);
    wr(2'd0, ctrl(0, 2, 3, 0, 0));
    exp_q.push_back(5);
    wr(2'd0, ctrl(1, 2, 3, 0, 0));
    check("R3 pulse high", int'(pulse), 1);
    rd(2'd3, v); check("R3 count zero at start", v, 0);
    wait_fall();
    rd(2'd3, v); check("R5 count holds compare", v, 5);
    rd(2'd0, v); check("R5 run auto-cleared", v & 1, 0);
    check("R6 irq set on match", int'(irq), 1);
    repeat (5) @(negedge clk);
    check("R6 irq sticky", int'(irq), 1);
    wr(2'd0, ctrl(0, 2, 3, 0, 1));
    check("R6 irq cleared by write", int'(irq), 0);

    // R4 trigger pin start with synchronizer latency
    wr(2'd1, 3);
    exp_q.push_back(3);
    @(negedge clk); trig = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R4 no output before sync", int'(pulse), 0);
    @(negedge clk);
    check("R4 output after third edge", int'(pulse), 1);
    wait_fall();
    trig = 1'b0;
    check("R6 irq from triggered pulse", int'(irq), 1);
    wr(2'd0, ctrl(0, 2, 3, 0, 1));

    // R4 trigger edge while active is ignored
    wr(2'd1, 20);
    exp_q.push_back(20);
    wr(2'd0, ctrl(1, 2, 3, 0, 0));
    repeat (4) @(negedge clk);
    trig = 1'b1;
    wait_fall();
    repeat (5) @(negedge clk);
    check("R4 no retrigger output", int'(pulse), 0);
    rd(2'd0, v); check("R4 no retrigger run", v & 1, 0);
    trig = 1'b0;
    wr(2'd0, ctrl(0, 2, 3, 0, 1));

    // R7 software clear mid-pulse
    wr(2'd1, 50);
    exp_q.push_back(8);
    wr(2'd0, ctrl(1, 2, 3, 0, 0));
    repeat (6) @(negedge clk);
    wr(2'd0, ctrl(0, 2, 3, 0, 0));
    check("R7 output low after clear", int'(pulse), 0);
    rd(2'd3, v); check("R7 count kept", v, 8);
    check("R7 no irq without match", int'(irq), 0);
    repeat (10) @(negedge clk);
    rd(2'd3, v); check("R8 count stable while idle", v, 8);

    // R8 restart zeroes counter
    exp_q.push_back(50);
    wr(2'd0, ctrl(1, 2, 3, 0, 0));
    rd(2'd3, v); check("R8 count zeroed on restart", v, 0);
    wait_fall();
    rd(2'd3, v); check("R8 full run after restart", v, 50);
    wr(2'd0, ctrl(0, 2, 3, 0, 1));

    // R9 period register and clear bit have no effect
    wr(2'd2, 2);
    wr(2'd0, ctrl(0, 2, 3, 1, 0));
    wr(2'd1, 4);
    exp_q.push_back(4);
    wr(2'd0, ctrl(1, 2, 3, 1, 0));
    wait_fall();
    rd(2'd3, v); check("R9 count reaches compare", v, 4);
    wr(2'd0, ctrl(0, 2, 3, 0, 1));

    // R2 wrong mode field: no output
    wr(2'd0, ctrl(0, 1, 3, 0, 0));
    wr(2'd0, ctrl(1, 1, 3, 0, 0));
    check("R2 no output in other mode", int'(pulse), 0);
    repeat (10) @(negedge clk);
    check("R2 still no output", int'(pulse), 0);
    check("R2 no irq in other mode", int'(irq), 0);
    wr(2'd0, ctrl(0, 1, 3, 0, 0));
    // R2 wrong output field: trigger ignored
    wr(2'd0, ctrl(0, 2, 2, 0, 0));
    trig = 1'b1;
    repeat (6) @(negedge clk);
    rd(2'd0, v); check("R2 trigger ignored", v & 1, 0);
    check("R2 output low", int'(pulse), 0);
    trig = 1'b0;

    // R11 software clear on the match edge, plus irq clear same cycle (R6)
    wr(2'd0, ctrl(0, 2, 3, 0, 0));
    wr(2'd1, 6);
    exp_q.push_back(6);
    wr(2'd0, ctrl(1, 2, 3, 0, 0));
    repeat (4) @(negedge clk);
    wr(2'd0, ctrl(0, 2, 3, 0, 1));
    check("R11 output low", int'(pulse), 0);
    rd(2'd0, v); check("R11 run low", v & 1, 0);
    check("R6 set wins over clear", int'(irq), 1);
    rd(2'd3, v); check("R11 count at compare", v, 6);
    wr(2'd0, ctrl(0, 2, 3, 0, 1));

    // R10 compare value 0 means full range
    wr(2'd1, 0);
    exp_q.push_back(1024);
    wr(2'd0, ctrl(1, 2, 3, 0, 0));
    wait_fall();
    rd(2'd3, v); check("R10 count wrapped", v, 0);
    check("R10 irq after full range", int'(irq), 1);

    repeat (3) @(negedge clk);
    check("R5 all expected pulses seen", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule